// File: doc/BRIEF.md
# Multi-Mode Inversion Link Encoder

This block sits in a network interface, in front of a link, and lowers the switching energy of the wires. Each body flit of width `PAYLOAD_W` goes out in one of four forms: unchanged, with its odd-indexed bits complemented, with its even-indexed bits complemented, or fully complemented. For each form the block works out a link cost against the word the link carried last. That cost counts the lines that rise from 0 to 1 and adds a coupling term for each pair of neighbouring lines. It then drives the cheapest form, together with a 2-bit mode code that tells the far end how to undo it.

Header flits are never altered, because routers along the path must read them. A header flit still becomes the reference word for the flit that follows it. Flits enter through a valid/ready handshake and leave through a single output register with its own valid/ready pair. That output register also holds the reference word.

Top module: `link_inv_encoder`

## Requirements
- R1: After reset `link_valid` is 0 and the reference word is all zeros, so the first flit is costed against an all-zero link.
- R2: `flit_ready` is 1 whenever the output register is empty or is being read in the same cycle (`link_ready` = 1). While `link_valid` = 1 and `link_ready` = 0, `flit_ready` is 0 and `link_data` and `link_mode` hold their values.
- R3: A flit accepted at a clock edge appears on `link_data`/`link_mode` with `link_valid` = 1 immediately after that edge.
- R4: A flit with `flit_head` = 1 is sent unchanged with mode 00. It still becomes the reference word for the next flit.
- R5: The mode codes and their masks, with `link_data` = payload XOR mask, are as follows. 00 means no change. 10 complements the odd-indexed bits (1, 3, 5, …). 01 complements the even-indexed bits (0, 2, 4, …). 11 complements all bits.
- R6: The cost of a candidate word C against reference P has two parts. The first is the number of bits with P=0 and C=1. The second is a sum over every adjacent pair (i, i+1). A pair scores 1 when exactly one of its two lines toggles. It scores 2 when both lines toggle and C[i] differs from C[i+1], so the lines move in opposite directions. It scores 0 otherwise.
- R7: For a body flit, the block drives the candidate with the lowest cost.
- R8: When costs tie, the first candidate wins in the order none, odd, even, full.
- R9: The reference word changes only when a flit is accepted. Idle cycles, stalled cycles and input data present without `flit_valid` leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| flit_valid | input | 1 | Input flit present |
| flit_ready | output | 1 | Block can take the input flit this cycle |
| flit_data | input | PAYLOAD_W | Flit payload |
| flit_head | input | 1 | Flit is a header and bypasses encoding |
| link_valid | output | 1 | Encoded word present on the link side |
| link_ready | input | 1 | Link side takes the word this cycle |
| link_data | output | PAYLOAD_W | Encoded payload |
| link_mode | output | 2 | Inversion mode code for the word on link_data |

## Verification
The bench tests ties on purpose. A reference word of all ones followed by an all-zero flit gives none and full equal cost. A selector that compares with "less or equal" would pick full instead of none.

It sends a header and then the same value as a body flit. A design that forgets to load header flits into the reference would then invert the body flit, when it should pass it unchanged.

A stall with a different flit waiting at the input checks two faults. A design that overwrites the held word would change the link during the stall. A design that loads the reference from the waiting flit would encode the next flit wrongly.

Long random runs with random backpressure compare every word against a cost model built from R6. This catches a swapped odd/even mask and a wrong pair weight.

// File: rtl/link_enc_pkg.sv
package link_enc_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_EVEN = 2'b01,
    MODE_ODD  = 2'b10,
    MODE_FULL = 2'b11
  } link_mode_e;

  localparam int NUM_CAND = 4;

  // Candidate index order is also the tie-break priority.
  function automatic link_mode_e cand_to_mode(input logic [1:0] idx);
    case (idx)
      2'd0:    cand_to_mode = MODE_NONE;
      2'd1:    cand_to_mode = MODE_ODD;
      2'd2:    cand_to_mode = MODE_EVEN;
      default: cand_to_mode = MODE_FULL;
    endcase
  endfunction

endpackage

// File: rtl/link_pair_classifier.sv
module link_pair_classifier #(
  parameter int W = 8
) (
  input  logic [W-1:0] prev_word,
  input  logic [W-1:0] cand_word,
  output logic [W-1:0] rise_vec,
  output logic [W-2:0] single_vec,
  output logic [W-2:0] opposed_vec
);

  logic [W-1:0] toggle;

  assign toggle   = prev_word ^ cand_word;
  assign rise_vec = ~prev_word & cand_word;

  for (genvar i = 0; i < W - 1; i++) begin : g_pair
    // exactly one line of the pair switches
    assign single_vec[i]  = toggle[i] ^ toggle[i+1];
    // both switch and end on different levels: opposite directions
    assign opposed_vec[i] = toggle[i] & toggle[i+1] & (cand_word[i] ^ cand_word[i+1]);
  end

endmodule

// File: rtl/link_ones_count.sv
module link_ones_count #(
  parameter int N  = 8,
  parameter int CW = 5
) (
  input  logic [N-1:0]  bits_in,
  output logic [CW-1:0] count_out
);

  always_comb begin
    count_out = '0;
    for (int i = 0; i < N; i++) begin
      count_out = count_out + CW'(bits_in[i]);
    end
  end

endmodule

// File: rtl/link_cand_cost.sv
module link_cand_cost #(
  parameter int W  = 8,
  parameter int CW = 5
) (
  input  logic [W-1:0]  prev_word,
  input  logic [W-1:0]  cand_word,
  output logic [CW-1:0] cost
);

  logic [W-1:0]  rise_vec;
  logic [W-2:0]  single_vec;
  logic [W-2:0]  opposed_vec;
  logic [CW-1:0] rise_n;
  logic [CW-1:0] single_n;
  logic [CW-1:0] opposed_n;

  link_pair_classifier #(.W(W)) u_class (
    .prev_word   (prev_word),
    .cand_word   (cand_word),
    .rise_vec    (rise_vec),
    .single_vec  (single_vec),
    .opposed_vec (opposed_vec)
  );

  link_ones_count #(.N(W), .CW(CW)) u_cnt_rise (
    .bits_in   (rise_vec),
    .count_out (rise_n)
  );

  link_ones_count #(.N(W-1), .CW(CW)) u_cnt_single (
    .bits_in   (single_vec),
    .count_out (single_n)
  );

  link_ones_count #(.N(W-1), .CW(CW)) u_cnt_opposed (
    .bits_in   (opposed_vec),
    .count_out (opposed_n)
  );

  assign cost = rise_n + single_n + (opposed_n << 1);

endmodule

// File: rtl/link_mode_select.sv
module link_mode_select #(
  parameter int CW = 5
) (
  input  logic [3:0][CW-1:0] cost_in,
  output logic [1:0]         win_idx
);

  logic [CW-1:0] best;

  always_comb begin
    best    = cost_in[0];
    win_idx = 2'd0;
    for (int k = 1; k < 4; k++) begin
      if (cost_in[k] < best) begin
        best    = cost_in[k];
        win_idx = 2'(k);
      end
    end
  end

endmodule

// File: rtl/link_inv_encoder.sv
module link_inv_encoder #(
  parameter int PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flit_valid,
  output logic                 flit_ready,
  input  logic [PAYLOAD_W-1:0] flit_data,
  input  logic                 flit_head,
  output logic                 link_valid,
  input  logic                 link_ready,
  output logic [PAYLOAD_W-1:0] link_data,
  output logic [1:0]           link_mode
);
  import link_enc_pkg::*;

  localparam int CW = $clog2(4 * PAYLOAD_W);

  logic [PAYLOAD_W-1:0]              odd_mask;
  logic [PAYLOAD_W-1:0]              even_mask;
  logic [NUM_CAND-1:0][PAYLOAD_W-1:0] cand_mask;
  logic [NUM_CAND-1:0][PAYLOAD_W-1:0] cand_word;
  logic [3:0][CW-1:0]                 cand_cost;
  logic [1:0]                         win_idx;

  logic                 out_valid_q, out_valid_d;
  logic [PAYLOAD_W-1:0] out_data_q,  out_data_d;
  logic [1:0]           out_mode_q,  out_mode_d;
  logic                 accept;
  logic [PAYLOAD_W-1:0] enc_data;
  logic [1:0]           enc_mode;

  for (genvar b = 0; b < PAYLOAD_W; b++) begin : g_mask
    assign odd_mask[b]  = (b % 2) == 1;
    assign even_mask[b] = (b % 2) == 0;
  end

  assign cand_mask[0] = '0;
  assign cand_mask[1] = odd_mask;
  assign cand_mask[2] = even_mask;
  assign cand_mask[3] = '1;

  // out_data_q doubles as the reference (last driven) link word
  for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
    assign cand_word[k] = flit_data ^ cand_mask[k];
    link_cand_cost #(.W(PAYLOAD_W), .CW(CW)) u_cost (
      .prev_word (out_data_q),
      .cand_word (cand_word[k]),
      .cost      (cand_cost[k])
    );
  end

  link_mode_select #(.CW(CW)) u_select (
    .cost_in (cand_cost),
    .win_idx (win_idx)
  );

  always_comb begin
    if (flit_head) begin
      enc_data = flit_data;
      enc_mode = MODE_NONE;
    end else begin
      enc_data = cand_word[win_idx];
      enc_mode = cand_to_mode(win_idx);
    end
  end

  assign flit_ready = !out_valid_q || link_ready;
  assign accept     = flit_valid && flit_ready;

  always_comb begin
    out_valid_d = out_valid_q;
    out_data_d  = out_data_q;
    out_mode_d  = out_mode_q;
    if (accept) begin
      out_valid_d = 1'b1;
      out_data_d  = enc_data;
      out_mode_d  = enc_mode;
    end else if (link_ready) begin
      out_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
      out_mode_q  <= MODE_NONE;
    end else begin
      out_valid_q <= out_valid_d;
      if (accept) begin
        out_data_q <= out_data_d;
        out_mode_q <= out_mode_d;
      end
    end
  end

  assign link_valid = out_valid_q;
  assign link_data  = out_data_q;
  assign link_mode  = out_mode_q;

endmodule

// File: rtl/link_inv_encoder_chk.sv
module link_inv_encoder_chk #(
  parameter int PAYLOAD_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flit_valid,
  input logic                 flit_ready,
  input logic [PAYLOAD_W-1:0] flit_data,
  input logic                 flit_head,
  input logic                 link_valid,
  input logic                 link_ready,
  input logic [PAYLOAD_W-1:0] link_data,
  input logic [1:0]           link_mode
);

  logic [PAYLOAD_W-1:0] undo_mask;
  logic                 fire_in;

  // odd lanes follow mode bit 1, even lanes follow mode bit 0
  for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_undo
    assign undo_mask[i] = (i % 2 == 1) ? link_mode[1] : link_mode[0];
  end

  assign fire_in = flit_valid && flit_ready;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && !link_ready |=> link_valid && $stable(link_data) && $stable(link_mode)); // R2

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && !link_ready |-> !flit_ready); // R2

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid && link_ready && !fire_in |=> !link_valid); // R2

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in |=> link_valid); // R3

  AST_HEAD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in && flit_head |=> link_data == $past(flit_data) && link_mode == 2'b00); // R4

  AST_BODY_UNDOES: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in && !flit_head |=> (link_data ^ undo_mask) == $past(flit_data)); // R5

  AST_REF_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_in |=> $stable(link_data) && $stable(link_mode)); // R9

endmodule

bind link_inv_encoder link_inv_encoder_chk #(.PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flit_valid (flit_valid),
  .flit_ready (flit_ready),
  .flit_data  (flit_data),
  .flit_head  (flit_head),
  .link_valid (link_valid),
  .link_ready (link_ready),
  .link_data  (link_data),
  .link_mode  (link_mode)
);

// File: tb/link_inv_encoder_bench.sv
`timescale 1ns/1ps
module link_inv_encoder_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         flit_valid;
  logic         flit_ready;
  logic [W-1:0] flit_data;
  logic         flit_head;
  logic         link_valid;
  logic         link_ready;
  logic [W-1:0] link_data;
  logic [1:0]   link_mode;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [W-1:0] ref_word;
  logic [W+1:0] exp_q[$];

  always #10 clk = ~clk;

  link_inv_encoder #(.PAYLOAD_W(W)) u_link_inv_encoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .flit_valid (flit_valid),
    .flit_ready (flit_ready),
    .flit_data  (flit_data),
    .flit_head  (flit_head),
    .link_valid (link_valid),
    .link_ready (link_ready),
    .link_data  (link_data),
    .link_mode  (link_mode)
  );

  // cost per R6
  function automatic int cost_of(input logic [W-1:0] p, input logic [W-1:0] c);
    int s = 0;
    for (int i = 0; i < W; i++) if (!p[i] && c[i]) s++;
    for (int i = 0; i < W - 1; i++) begin
      bit ta = p[i] != c[i];
      bit tb = p[i+1] != c[i+1];
      if (ta != tb) s += 1;
      else if (ta && tb && (c[i] != c[i+1])) s += 2;
    end
    return s;
  endfunction

  // expected {mode, data} per R4, R5, R7, R8
  function automatic logic [W+1:0] expect_word(input logic [W-1:0] p,
                                               input logic [W-1:0] d,
                                               input logic head);
    logic [W-1:0] masks [4];
    logic [1:0]   codes [4];
    int           best;
    logic [W+1:0] res;
    masks[0] = 8'h00; codes[0] = 2'b00;
    masks[1] = 8'hAA; codes[1] = 2'b10;
    masks[2] = 8'h55; codes[2] = 2'b01;
    masks[3] = 8'hFF; codes[3] = 2'b11;
    if (head) return {2'b00, d};
    best = cost_of(p, d);
    res  = {2'b00, d};
    for (int k = 1; k < 4; k++) begin
      if (cost_of(p, d ^ masks[k]) < best) begin
        best = cost_of(p, d ^ masks[k]);
        res  = {codes[k], d ^ masks[k]};
      end
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one flit with the link side ready, check the word that follows
  task automatic send(input string req, input logic [W-1:0] d, input logic head,
                      input logic [W+1:0] exp);
    @(negedge clk);
    flit_valid = 1'b1; flit_data = d; flit_head = head; link_ready = 1'b1;
    @(negedge clk);
    flit_valid = 1'b0; flit_data = 8'h3C;
    check({req, " valid"}, {9'd0, link_valid}, 10'd1);
    check(req, {link_mode, link_data}, exp);
    ref_word = exp[W-1:0];
  endtask

  task automatic t_reset;
    rst_n = 1'b0; flit_valid = 1'b0; flit_data = '0; flit_head = 1'b0; link_ready = 1'b0;
    ref_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 idle after reset", {9'd0, link_valid}, 10'd0);
    check("R2 ready when empty", {9'd0, flit_ready}, 10'd1);
  endtask

  task automatic t_directed;
    send("R1 R7 zero reference picks full", 8'hFF, 1'b0, {2'b11, 8'h00});
    send("R4 head sent raw", 8'hFF, 1'b1, {2'b00, 8'hFF});
    send("R4 head loads reference", 8'hFF, 1'b0, {2'b00, 8'hFF});
    send("R8 none beats full on tie", 8'h00, 1'b0, {2'b00, 8'h00});
    send("R5 R7 odd inversion", 8'hAA, 1'b0, {2'b10, 8'h00});
    send("R5 R7 even inversion", 8'h55, 1'b0, {2'b01, 8'h00});
    send("R6 model case", 8'h3A, 1'b0, expect_word(ref_word, 8'h3A, 1'b0));
  endtask

  task automatic t_stall;
    logic [W+1:0] ea;
    logic [W+1:0] eb;
    @(negedge clk);
    ea = expect_word(ref_word, 8'hC3, 1'b0);
    flit_valid = 1'b1; flit_data = 8'hC3; flit_head = 1'b0; link_ready = 1'b0;
    @(negedge clk);
    flit_data = 8'h5F;
    #1;
    check("R2 ready low in stall", {9'd0, flit_ready}, 10'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 word held in stall", {link_mode, link_data}, ea);
    end
    eb = expect_word(ea[W-1:0], 8'h5F, 1'b0);
    link_ready = 1'b1;
    @(negedge clk);
    flit_valid = 1'b0;
    check("R9 R3 flit after stall", {link_mode, link_data}, eb);
    ref_word = eb[W-1:0];
  endtask

  task automatic t_idle_junk;
    @(negedge clk);
    flit_valid = 1'b0; link_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      flit_data = 8'(i * 37 + 11); flit_head = i[0];
      @(negedge clk);
    end
    check("R2 empty when idle", {9'd0, link_valid}, 10'd0);
    send("R9 idle data ignored", 8'h96, 1'b0, expect_word(ref_word, 8'h96, 1'b0));
  endtask

  task automatic t_random;
    logic [W+1:0] e;
    @(negedge clk);
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      link_ready = ($urandom % 4) != 0;
      flit_valid = ($urandom % 3) != 0;
      flit_data  = W'($urandom);
      flit_head  = ($urandom % 6) == 0;
      #1;
      if (link_valid && link_ready) begin
        if (exp_q.size() == 0) check("R3 unexpected word", {link_mode, link_data}, 'x);
        else check("R6 R7 R8 random", {link_mode, link_data}, exp_q.pop_front());
      end
      if (flit_valid && flit_ready) begin
        e = expect_word(ref_word, flit_data, flit_head);
        exp_q.push_back(e);
        ref_word = e[W-1:0];
      end
    end
    @(negedge clk);
    flit_valid = 1'b0; link_ready = 1'b1;
    #1;
    if (link_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected word", {link_mode, link_data}, 'x);
      else check("R6 R7 R8 random drain", {link_mode, link_data}, exp_q.pop_front());
    end
    check("R3 all words delivered", 10'(exp_q.size()), 10'd0);
  endtask

  initial begin
    t_reset();
    t_directed();
    t_stall();
    t_idle_junk();
    t_random();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule